// File: doc/BRIEF.md
# Multi-Lane Serial Memory Read Engine

This block is the master side of a read from a serial memory that can return data on one, two or four lines per clock. A host hands over one request: a command byte, an address, a lane count, a number of dummy clocks and a byte count. The engine lowers the select and shifts the command byte out on IO0, one bit per clock. The address follows on the same line in the same way. The engine then stops driving IO0, runs the dummy clocks, and gathers read data on one, two or four lines. Finished bytes leave on a valid/ready stream.

The serial clock is made from the system clock. It idles low and stays high for exactly one system cycle. Outgoing data changes only on the falling edge, and both sides sample on the rising edge. The low phase can be stretched. The engine stretches it whenever the next sample would finish a byte while the previous byte is still waiting at the output. In that way a stalled consumer pauses the memory, and no byte is dropped or repeated.

Top module: `qread_engine`

## Requirements
- R1: After reset, csN is 1, sclk is 0, dataOe is 0, rdValid is 0 and reqReady is 1.
- R2: sclk is 0 whenever csN is 1. Each sclk high phase lasts exactly one system cycle. dataOut never changes while sclk is 1.
- R3: On every lane setting, the first 8 rising edges of sclk carry reqCmd on dataOut, MSB first. The next ADDR_W rising edges carry reqAddr, MSB first.
- R4: dataOe rises together with the select. It stays 1 through the rising edge of the last address bit, is 0 at every later rising edge of the transfer, and is 0 while csN is 1.
- R5: Exactly reqDummy rising edges come between the last address bit and the first data sample. reqDummy = 0 is allowed.
- R6: Lane code 0 (single): one bit per rising edge is taken from ioIn[1], MSB first.
- R7: Lane code 1 (dual): each rising edge takes two bits. ioIn[1] carries bits 7, 5, 3, 1 and ioIn[0] carries bits 6, 4, 2, 0, so bits 7 and 6 come on the first clock.
- R8: Lane codes 2 and 3 (quad): ioIn[3:0] carries bits 7..4 on the first clock of a byte and bits 3..0 on the second.
- R9: A request with length field reqLenM1 delivers exactly reqLenM1+1 bytes, in order. The data phase uses exactly (reqLenM1+1)*8/lanes rising edges.
- R10: While rdValid is 1 and rdReady is 0, rdValid and rdData hold. Once a second byte is complete, no further sclk rising edge occurs until the first byte is taken.
- R11: reqReady is 1 only while the engine is idle and the output is empty, and a request presented during a transfer is ignored. csN stays 0 from acceptance until the last data sample and returns to 1 one cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted on this edge if reqValid is 1 |
| reqCmd | input | 8 | Command byte |
| reqAddr | input | ADDR_W | Read address |
| reqLanes | input | 2 | Data lanes: 0 single, 1 dual, 2 or 3 quad |
| reqLenM1 | input | LEN_W | Number of bytes minus one |
| reqDummy | input | DUMMY_W | Dummy clocks after the address |
| csN | output | 1 | Memory select, active low |
| sclk | output | 1 | Serial clock, idles low |
| dataOut | output | 1 | Value driven on IO0 |
| dataOe | output | 1 | Output enable for IO0 |
| ioIn | input | 4 | Sampled levels of IO3..IO0 |
| rdData | output | 8 | Received byte |
| rdValid | output | 1 | rdData holds a byte |
| rdReady | input | 1 | Consumer takes rdData |

## Verification
csN falls and dataOe rises on the edge that accepts the request. Each serial bit then takes at least two system cycles. A byte appears on rdValid at the edge that ends the sclk high phase of its last sample, and csN returns high one cycle after the final sample. The bench never samples at a fixed cycle offset. It plays the memory side at the falling edge of the system clock: it counts sclk rising and falling transitions there, captures IO0 at each rise, and puts the next memory bit on ioIn after each fall. Every check is therefore tied to the serial edge it concerns, however long a stall stretches the low phase. Stall checks compare snapshots taken 50 cycles apart.

// File: rtl/qread_pkg.sv
package qread_pkg;

  localparam logic [1:0] LANES_1 = 2'd0;
  localparam logic [1:0] LANES_2 = 2'd1;
  localparam logic [1:0] LANES_4 = 2'd2;

  typedef struct packed {
    logic load;
    logic txShift;
    logic rxSample;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_END
  } xferState_t;

endpackage

// File: rtl/qread_datapath.sv
module qread_datapath
  import qread_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [7:0]        cmdByte,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        laneMode,
  input  logic [3:0]        ioIn,
  input  logic              rdReady,
  output logic              dataOut,
  output logic [7:0]        rdData,
  output logic              rdValid,
  output logic              byteEnd
);

  localparam int TX_W = 8 + ADDR_W;

  logic [TX_W-1:0] txReg;
  logic [1:0]      laneR;
  logic [2:0]      slotCnt;
  logic [2:0]      lastSlot;
  logic [7:0]      rxReg;
  logic [7:0]      rxNext;
  logic [7:0]      dataReg;
  logic            validR;

  // outgoing shift register: command then address, MSB first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg <= '0;
    end else if (stb.load) begin
      txReg <= {cmdByte, addr};
    end else if (stb.txShift) begin
      txReg <= {txReg[TX_W-2:0], 1'b0};
    end
  end

  assign dataOut = txReg[TX_W-1];

  // slots per byte depend on the lane count
  always_comb begin
    case (laneR)
      LANES_1: lastSlot = 3'd7;
      LANES_2: lastSlot = 3'd3;
      default: lastSlot = 3'd1;
    endcase
  end

  // lane interleave: higher-numbered line carries the more significant bit
  always_comb begin
    case (laneR)
      LANES_1: rxNext = {rxReg[6:0], ioIn[1]};
      LANES_2: rxNext = {rxReg[5:0], ioIn[1], ioIn[0]};
      default: rxNext = {rxReg[3:0], ioIn[3:0]};
    endcase
  end

  assign byteEnd = (slotCnt == lastSlot);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      laneR   <= LANES_1;
      slotCnt <= '0;
      rxReg   <= '0;
    end else if (stb.load) begin
      laneR   <= laneMode;
      slotCnt <= '0;
    end else if (stb.rxSample) begin
      rxReg   <= rxNext;
      slotCnt <= byteEnd ? 3'd0 : slotCnt + 3'd1;
    end
  end

  // single output holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validR  <= 1'b0;
      dataReg <= '0;
    end else begin
      if (validR && rdReady) validR <= 1'b0;
      if (stb.rxSample && byteEnd) begin
        validR  <= 1'b1;
        dataReg <= rxNext;
      end
    end
  end

  assign rdData  = dataReg;
  assign rdValid = validR;

endmodule

// File: rtl/qread_control.sv
module qread_control
  import qread_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int LEN_W   = 16,
  parameter int DUMMY_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [LEN_W-1:0]   lenM1,
  input  logic [DUMMY_W-1:0] dummyClks,
  input  logic               byteEnd,
  input  logic               rdValid,
  input  logic               rdReady,
  output logic               reqReady,
  output logic               csN,
  output logic               sclk,
  output logic               dataOe,
  output dpStrobe_t          stb
);

  localparam int SEG_SPAN = (ADDR_W > (1 << DUMMY_W)) ? ADDR_W : (1 << DUMMY_W);
  localparam int SEG_W    = $clog2(SEG_SPAN) + 1;

  xferState_t         state;
  logic               sclkR;
  logic               csNR;
  logic               oeR;
  logic [SEG_W-1:0]   segCnt;
  logic [LEN_W-1:0]   byteLeft;
  logic [DUMMY_W-1:0] dummyR;

  logic accept;
  logic inXfer;
  logic outBlocked;
  logic lowGo;
  logic highEnd;

  assign reqReady   = (state == ST_IDLE) && !rdValid;
  assign accept     = reqValid && reqReady;
  assign inXfer     = (state == ST_CMD) || (state == ST_ADDR) ||
                      (state == ST_DUMMY) || (state == ST_DATA);
  // hold the low phase if this sample would finish a byte into a full output
  assign outBlocked = (state == ST_DATA) && byteEnd && rdValid && !rdReady;
  assign lowGo      = inXfer && !sclkR && !outBlocked;
  assign highEnd    = inXfer && sclkR;

  always_comb begin
    stb          = '0;
    stb.load     = accept;
    stb.txShift  = highEnd && ((state == ST_CMD) || (state == ST_ADDR));
    stb.rxSample = highEnd && (state == ST_DATA);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      sclkR    <= 1'b0;
      csNR     <= 1'b1;
      oeR      <= 1'b0;
      segCnt   <= '0;
      byteLeft <= '0;
      dummyR   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_CMD;
            csNR     <= 1'b0;
            oeR      <= 1'b1;
            segCnt   <= '0;
            byteLeft <= lenM1;
            dummyR   <= dummyClks;
          end
        end
        ST_END: begin
          csNR  <= 1'b1;
          state <= ST_IDLE;
        end
        default: begin
          if (lowGo) sclkR <= 1'b1;
          if (highEnd) begin
            sclkR <= 1'b0;
            case (state)
              ST_CMD: begin
                if (segCnt == SEG_W'(7)) begin
                  state  <= ST_ADDR;
                  segCnt <= '0;
                end else begin
                  segCnt <= segCnt + 1'b1;
                end
              end
              ST_ADDR: begin
                if (segCnt == SEG_W'(ADDR_W - 1)) begin
                  oeR    <= 1'b0;
                  segCnt <= '0;
                  state  <= (dummyR == '0) ? ST_DATA : ST_DUMMY;
                end else begin
                  segCnt <= segCnt + 1'b1;
                end
              end
              ST_DUMMY: begin
                if (segCnt + 1'b1 == SEG_W'(dummyR)) begin
                  segCnt <= '0;
                  state  <= ST_DATA;
                end else begin
                  segCnt <= segCnt + 1'b1;
                end
              end
              ST_DATA: begin
                if (byteEnd) begin
                  if (byteLeft == '0) state <= ST_END;
                  else                byteLeft <= byteLeft - 1'b1;
                end
              end
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  assign csN    = csNR;
  assign sclk   = sclkR;
  assign dataOe = oeR;

endmodule

// File: rtl/qread_engine.sv
module qread_engine
  import qread_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int LEN_W   = 16,
  parameter int DUMMY_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [7:0]         reqCmd,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [1:0]         reqLanes,
  input  logic [LEN_W-1:0]   reqLenM1,
  input  logic [DUMMY_W-1:0] reqDummy,
  output logic               csN,
  output logic               sclk,
  output logic               dataOut,
  output logic               dataOe,
  input  logic [3:0]         ioIn,
  output logic [7:0]         rdData,
  output logic               rdValid,
  input  logic               rdReady
);

  dpStrobe_t stb;
  logic      byteEnd;

  qread_control #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .DUMMY_W(DUMMY_W)
  ) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .lenM1    (reqLenM1),
    .dummyClks(reqDummy),
    .byteEnd  (byteEnd),
    .rdValid  (rdValid),
    .rdReady  (rdReady),
    .reqReady (reqReady),
    .csN      (csN),
    .sclk     (sclk),
    .dataOe   (dataOe),
    .stb      (stb)
  );

  qread_datapath #(
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .cmdByte (reqCmd),
    .addr    (reqAddr),
    .laneMode(reqLanes),
    .ioIn    (ioIn),
    .rdReady (rdReady),
    .dataOut (dataOut),
    .rdData  (rdData),
    .rdValid (rdValid),
    .byteEnd (byteEnd)
  );

endmodule

// File: rtl/qread_checker.sv
module qread_checker (
  input logic       clk,
  input logic       rstN,
  input logic       reqReady,
  input logic       csN,
  input logic       sclk,
  input logic       dataOut,
  input logic       dataOe,
  input logic [7:0] rdData,
  input logic       rdValid,
  input logic       rdReady
);

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk); // R2

  AST_SCLK_HIGH_ONE: assert property (@(posedge clk) disable iff (!rstN)
    sclk |=> !sclk); // R2

  AST_DOUT_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> $stable(dataOut)); // R2

  AST_OE_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !dataOe); // R4

  AST_OE_WITH_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataOe) |-> $fell(csN)); // R4

  AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdData))); // R10

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (csN && !rdValid)); // R11

endmodule

bind qread_engine qread_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqReady(reqReady),
  .csN     (csN),
  .sclk    (sclk),
  .dataOut (dataOut),
  .dataOe  (dataOe),
  .rdData  (rdData),
  .rdValid (rdValid),
  .rdReady (rdReady)
);

// File: tb/tb_qread_engine.sv
`timescale 1ns/1ps
module tb_qread_engine;

  localparam int AW  = 24;
  localparam int LW  = 8;
  localparam int DW  = 4;
  localparam int TXB = 8 + AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN;
  logic          reqValid;
  logic          reqReady;
  logic [7:0]    reqCmd;
  logic [AW-1:0] reqAddr;
  logic [1:0]    reqLanes;
  logic [LW-1:0] reqLenM1;
  logic [DW-1:0] reqDummy;
  logic          csN;
  logic          sclk;
  logic          dataOut;
  logic          dataOe;
  logic [3:0]    ioIn;
  logic [7:0]    rdData;
  logic          rdValid;
  logic          rdReady;

  qread_engine #(.ADDR_W(AW), .LEN_W(LW), .DUMMY_W(DW)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqCmd(reqCmd), .reqAddr(reqAddr), .reqLanes(reqLanes),
    .reqLenM1(reqLenM1), .reqDummy(reqDummy), .csN(csN), .sclk(sclk),
    .dataOut(dataOut), .dataOe(dataOe), .ioIn(ioIn), .rdData(rdData),
    .rdValid(rdValid), .rdReady(rdReady)
  );

  int checks = 0;
  int errors = 0;

  int riseCnt, fallCnt, r0, curMode, curSeed, rxCount, oeViol, r2Viol;
  int readyMode, cyc, stallCnt, snapRise;
  bit stallDone, prevSclk, prevDout;
  logic [7:0]     snapData;
  logic [TXB-1:0] txCap;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] byteVal(int j, int s);
    return 8'((j * 73 + s * 29 + 17) & 255);
  endfunction

  function automatic string modeTag(int m);
    if (m == 0) return "R6";
    if (m == 1) return "R7";
    return "R8";
  endfunction

  // memory model: value to present for rising edge number r (0-based)
  function automatic logic [3:0] slaveOut(int r);
    int k;
    logic [7:0] b;
    logic [3:0] v;
    v = 4'b1101;
    if (r >= r0) begin
      k = r - r0;
      case (curMode)
        0: begin b = byteVal(k / 8, curSeed); v = {2'b11, b[7 - (k % 8)], 1'b1}; end
        1: begin b = byteVal(k / 4, curSeed); v = {2'b11, b[7 - 2 * (k % 4)], b[6 - 2 * (k % 4)]}; end
        default: begin b = byteVal(k / 2, curSeed); v = (k % 2 == 0) ? b[7:4] : b[3:0]; end
      endcase
    end
    return v;
  endfunction

  // bench-side memory and consumer, all on the falling system clock edge
  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (!csN) begin
        if (sclk && !prevSclk) begin
          if (riseCnt < TXB) begin
            txCap = {txCap[TXB-2:0], dataOut};
            if (!dataOe) oeViol++;
          end else if (dataOe) begin
            oeViol++;
          end
          riseCnt++;
        end
        if (!sclk && prevSclk) begin
          fallCnt++;
          ioIn = slaveOut(fallCnt);
        end
        if (sclk && (dataOut != prevDout)) r2Viol++;
      end
      prevSclk = sclk;
      prevDout = dataOut;
      case (readyMode)
        1: rdReady = (cyc % 3 != 0);
        2: begin
          if (rdValid && !stallDone) begin
            stallCnt++;
            rdReady = 1'b0;
            if (stallCnt == 30) begin
              snapRise = riseCnt;
              snapData = rdData;
            end
            if (stallCnt == 80) begin
              chk(riseCnt == snapRise, "R10", "sclk paused while output full", riseCnt, snapRise);
              chk(rdData == snapData, "R10", "held byte stable", rdData, snapData);
              stallDone = 1'b1;
            end
          end else begin
            rdReady = 1'b1;
          end
        end
        default: rdReady = 1'b1;
      endcase
      if (rdValid && rdReady) begin
        chk(rdData == byteVal(rxCount, curSeed), modeTag(curMode), "data byte",
            rdData, byteVal(rxCount, curSeed));
        rxCount++;
      end
    end
  end

  task automatic runXfer(input int mode, input int dummy, input int nBytes,
                         input int seed, input int rdyMode, input bit poke);
    logic [7:0]    cmd;
    logic [AW-1:0] ad;
    int lanes, expRises, t;
    cmd = 8'((seed * 37 + 11) & 255);
    ad  = AW'((seed * 32'h01F3C7) ^ 32'hA5C3E1);
    lanes = (mode == 0) ? 1 : (mode == 1) ? 2 : 4;
    curMode = mode; curSeed = seed; r0 = TXB + dummy;
    riseCnt = 0; fallCnt = 0; rxCount = 0; oeViol = 0; r2Viol = 0;
    readyMode = rdyMode; stallCnt = 0; stallDone = 1'b0; txCap = '0;
    ioIn = slaveOut(0);
    reqCmd = cmd; reqAddr = ad; reqLanes = 2'(mode);
    reqLenM1 = LW'(nBytes - 1); reqDummy = DW'(dummy);
    reqValid = 1'b1;
    t = 0;
    while (!reqReady && t < 1000) begin @(negedge clk); t++; end
    @(negedge clk);
    reqValid = 1'b0;
    if (poke) begin
      repeat (10) @(negedge clk);
      reqValid = 1'b1;
      reqCmd = 8'hFF;
      chk(reqReady == 1'b0, "R11", "reqReady during transfer", reqReady, 0);
      repeat (4) @(negedge clk);
      reqValid = 1'b0;
    end
    t = 0;
    while (!(rxCount == nBytes && csN) && t < 20000) begin @(negedge clk); t++; end
    repeat (6) @(negedge clk);
    expRises = TXB + dummy + nBytes * 8 / lanes;
    chk(txCap == {cmd, ad}, "R3", "command and address bits", txCap, {cmd, ad});
    chk(oeViol == 0, "R4", "output enable at rising edges", oeViol, 0);
    chk(riseCnt == expRises, "R5/R9", "rising edge total", riseCnt, expRises);
    chk(rxCount == nBytes, "R9", "bytes delivered", rxCount, nBytes);
    chk(r2Viol == 0, "R2", "IO0 change while sclk high", r2Viol, 0);
    chk(csN == 1'b1, "R11", "select released after transfer", csN, 1);
    if (rdyMode == 2) chk(stallDone, "R10", "stall observed", stallDone, 1);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL R9 watchdog expired: actual=hung expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    rstN = 1'b0; reqValid = 1'b0; reqCmd = '0; reqAddr = '0; reqLanes = '0;
    reqLenM1 = '0; reqDummy = '0; ioIn = '0; rdReady = 1'b0;
    riseCnt = 0; fallCnt = 0; rxCount = 0; cyc = 0; readyMode = 0;
    prevSclk = 1'b0; prevDout = 1'b0; stallDone = 1'b0; r0 = TXB;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(csN == 1'b1, "R1", "csN after reset", csN, 1);
    chk(sclk == 1'b0, "R1", "sclk after reset", sclk, 0);
    chk(dataOe == 1'b0, "R1", "dataOe after reset", dataOe, 0);
    chk(rdValid == 1'b0, "R1", "rdValid after reset", rdValid, 0);
    chk(reqReady == 1'b1, "R1", "reqReady after reset", reqReady, 1);

    seed = 1;
    for (int m = 0; m < 4; m++) begin
      for (int di = 0; di < 3; di++) begin
        for (int nb = 1; nb <= 3; nb += 2) begin
          runXfer(m, (di == 0) ? 0 : (di == 1) ? 2 : 7, nb, seed, seed % 2, 1'b0);
          seed++;
        end
      end
    end
    runXfer(2, 3, 4, seed, 2, 1'b0); seed++;   // R10 quad stall
    runXfer(0, 1, 2, seed, 2, 1'b0); seed++;   // R10 single stall
    runXfer(1, 0, 3, seed, 1, 1'b1); seed++;   // R11 request while busy

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule